// File: doc/BRIEF.md
# Instruction Cycle Sequencer

This block is the control sequencer and register set of a small accumulator machine. It steps each instruction through register-transfer subcycles. In the fetch subcycle the program counter is copied into the memory address register and the instruction word is read. An optional indirect subcycle follows, which swaps the address field for a pointer read from memory. The execute subcycle performs a load, store, add or jump. An interrupt subcycle can follow execute: it pushes the program counter onto a downward-growing save stack and branches to a fixed handler.

All memory traffic goes through a single-port interface. The address always comes from the memory address register and write data always comes from the memory buffer register. A strobe stays raised until the memory answers with ready, so any number of wait states is tolerated. A one-cycle pulse on an input sets the interrupt-enable flag. Taking an interrupt clears that flag.

Top module: `instrCycleCtl`

## Requirements
- R1: While reset is held and on the first cycle after it, the PC is 0, the phase is fetch (encoding 0), interrupt enable is 0 and neither memory strobe is raised.
- R2: Every instruction starts with a read at the current PC. The PC increments by one when that read's ready arrives.
- R3: The instruction word is bits 15:12 opcode, bit 11 indirect, bits 10:0 address. With the indirect bit set, a read of the address field runs in the indirect phase (encoding 1), and the low 11 bits of the returned word become the effective address. With the bit clear, the indirect phase never appears.
- R4: Opcode 1 loads the word at the effective address into the accumulator. Opcode 2 writes the accumulator to that address. Opcode 3 adds the word to the accumulator modulo 2^16. Opcode 4 loads the PC with the effective address. The execute phase has encoding 2.
- R5: All other opcodes change neither the accumulator nor memory, and the next instruction is fetched from the following address.
- R6: A raised read or write strobe keeps its address (and write data) unchanged until ready. Read and write are never raised together.
- R7: An interrupt request is honoured only at the end of an execute phase while interrupt enable is 1. Otherwise it has no effect.
- R8: An honoured interrupt runs the interrupt phase (encoding 3). It writes the PC that would have been fetched next to the save pointer (starting at 0x7FF, decremented after each save), clears interrupt enable, and then fetches from the handler address 0x100.
- R9: A one-cycle pulse on `intEnSet` sets interrupt enable. Clearing on interrupt entry takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| intReq | input | 1 | Interrupt request level |
| intEnSet | input | 1 | Pulse that sets interrupt enable |
| memAddr | output | 11 | Memory address (memory address register) |
| memRd | output | 1 | Read strobe, held until ready |
| memWr | output | 1 | Write strobe, held until ready |
| memWdata | output | 16 | Write data (memory buffer register) |
| memRdata | input | 16 | Read data, valid with ready |
| memReady | input | 1 | Completes the pending access |
| pcOut | output | 11 | Program counter |
| accOut | output | 16 | Accumulator |
| intEnOut | output | 1 | Interrupt enable flag |
| phase | output | 2 | Subcycle: 0 fetch, 1 indirect, 2 execute, 3 interrupt |

## Verification
A wrong sequencer state shows up within one memory handshake. A stray or missing indirect phase makes the next access hit the pointer address instead of the operand, so the stored or accumulated values in memory come out wrong. A wrong PC update sends the next fetch to the wrong address, and the bench sees this through skipped or duplicated stores and a PC that does not settle in the closing self-loop. A broken interrupt entry shows in the save-stack words, the handler's store and the enable flag a few cycles after the execute phase that should have ended in it.

// File: rtl/iccPkg.sv
package iccPkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_LOAD  = 4'd1;
  localparam logic [OPC_W-1:0] OP_STORE = 4'd2;
  localparam logic [OPC_W-1:0] OP_ADD   = 4'd3;
  localparam logic [OPC_W-1:0] OP_JUMP  = 4'd4;

  localparam logic [1:0] PH_FETCH = 2'd0;
  localparam logic [1:0] PH_IND   = 2'd1;
  localparam logic [1:0] PH_EXEC  = 2'd2;
  localparam logic [1:0] PH_INT   = 2'd3;

  typedef enum logic [3:0] {
    S_FADDR, S_FREAD, S_FIR,
    S_IREAD, S_IADDR,
    S_EXEC, S_XWRITE,
    S_ISAVE, S_IWRITE
  } cycState_t;

  typedef struct packed {
    logic marFromPc;
    logic marFromMbr;
    logic marFromSp;
    logic mbrFromMem;
    logic mbrFromAcc;
    logic mbrFromPc;
    logic irFromMbr;
    logic pcInc;
    logic pcFromMar;
    logic pcToHandler;
    logic spDec;
    logic accLoad;
    logic accAdd;
    logic intEnClr;
    logic memRd;
    logic memWr;
  } ctlStrobe_t;

endpackage

// File: rtl/iccDatapath.sv
module iccDatapath
  import iccPkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 11,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = 11'h100,
  parameter logic [ADDR_W-1:0] SP_INIT = 11'h7FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic              intEnSet,
  input  logic [WORD_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [OPC_W-1:0]  irOp,
  output logic              mbrInd,
  output logic              intEn,
  output logic [ADDR_W-1:0] pcOut,
  output logic [WORD_W-1:0] accOut
);

  localparam int PAD_W = WORD_W - ADDR_W;

  logic [ADDR_W-1:0] pc, mar, sp;
  logic [WORD_W-1:0] mbr, ir, acc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc    <= '0;
      mar   <= '0;
      sp    <= SP_INIT;
      mbr   <= '0;
      ir    <= '0;
      acc   <= '0;
      intEn <= 1'b0;
    end else begin
      if (strobe.marFromPc)       mar <= pc;
      else if (strobe.marFromMbr) mar <= mbr[ADDR_W-1:0];
      else if (strobe.marFromSp)  mar <= sp;

      if (strobe.mbrFromMem)      mbr <= memRdata;
      else if (strobe.mbrFromAcc) mbr <= acc;
      else if (strobe.mbrFromPc)  mbr <= {{PAD_W{1'b0}}, pc};

      if (strobe.irFromMbr) ir <= mbr;

      if (strobe.pcInc)            pc <= pc + 1'b1;
      else if (strobe.pcFromMar)   pc <= mar;
      else if (strobe.pcToHandler) pc <= HANDLER_ADDR;

      if (strobe.spDec) sp <= sp - 1'b1;

      if (strobe.accLoad)     acc <= memRdata;
      else if (strobe.accAdd) acc <= acc + memRdata;

      if (strobe.intEnClr)  intEn <= 1'b0;
      else if (intEnSet)    intEn <= 1'b1;
    end
  end

  assign memAddr  = mar;
  assign memWdata = mbr;
  assign irOp     = ir[WORD_W-1 -: OPC_W];
  assign mbrInd   = mbr[ADDR_W];
  assign pcOut    = pc;
  assign accOut   = acc;

endmodule

// File: rtl/iccControl.sv
module iccControl
  import iccPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             memReady,
  input  logic             mbrInd,
  input  logic [OPC_W-1:0] irOp,
  input  logic             intEn,
  input  logic             intReq,
  output ctlStrobe_t       strobe,
  output logic [1:0]       phase
);

  cycState_t state, nextState;
  logic execDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_FADDR;
    else       state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    execDone  = 1'b0;
    unique case (state)
      S_FADDR: begin
        strobe.marFromPc = 1'b1;
        nextState = S_FREAD;
      end
      S_FREAD: begin
        strobe.memRd = 1'b1;
        if (memReady) begin
          strobe.mbrFromMem = 1'b1;
          strobe.pcInc = 1'b1;
          nextState = S_FIR;
        end
      end
      S_FIR: begin
        strobe.irFromMbr  = 1'b1;
        strobe.marFromMbr = 1'b1;
        nextState = mbrInd ? S_IREAD : S_EXEC;
      end
      S_IREAD: begin
        strobe.memRd = 1'b1;
        if (memReady) begin
          strobe.mbrFromMem = 1'b1;
          nextState = S_IADDR;
        end
      end
      S_IADDR: begin
        strobe.marFromMbr = 1'b1;
        nextState = S_EXEC;
      end
      S_EXEC: begin
        case (irOp)
          OP_LOAD, OP_ADD: begin
            strobe.memRd = 1'b1;
            if (memReady) begin
              strobe.mbrFromMem = 1'b1;
              strobe.accLoad = (irOp == OP_LOAD);
              strobe.accAdd  = (irOp == OP_ADD);
              execDone = 1'b1;
            end
          end
          OP_STORE: begin
            strobe.mbrFromAcc = 1'b1;
            nextState = S_XWRITE;
          end
          OP_JUMP: begin
            strobe.pcFromMar = 1'b1;
            execDone = 1'b1;
          end
          default: execDone = 1'b1;
        endcase
      end
      S_XWRITE: begin
        strobe.memWr = 1'b1;
        if (memReady) execDone = 1'b1;
      end
      S_ISAVE: begin
        strobe.mbrFromPc = 1'b1;
        strobe.marFromSp = 1'b1;
        strobe.intEnClr  = 1'b1;
        nextState = S_IWRITE;
      end
      S_IWRITE: begin
        strobe.memWr    = 1'b1;
        strobe.intEnClr = 1'b1;
        if (memReady) begin
          strobe.pcToHandler = 1'b1;
          strobe.spDec = 1'b1;
          nextState = S_FADDR;
        end
      end
      default: nextState = S_FADDR;
    endcase
    if (execDone) nextState = (intReq && intEn) ? S_ISAVE : S_FADDR;
  end

  always_comb begin
    unique case (state)
      S_IREAD, S_IADDR:  phase = PH_IND;
      S_EXEC, S_XWRITE:  phase = PH_EXEC;
      S_ISAVE, S_IWRITE: phase = PH_INT;
      default:           phase = PH_FETCH;
    endcase
  end

endmodule

// File: rtl/instrCycleCtl.sv
module instrCycleCtl
  import iccPkg::*;
#(
  parameter int WORD_W = 16,
  parameter logic [WORD_W-OPC_W-2:0] HANDLER_ADDR = 'h100,
  parameter logic [WORD_W-OPC_W-2:0] SP_INIT = '1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      intReq,
  input  logic                      intEnSet,
  output logic [WORD_W-OPC_W-2:0]   memAddr,
  output logic                      memRd,
  output logic                      memWr,
  output logic [WORD_W-1:0]         memWdata,
  input  logic [WORD_W-1:0]         memRdata,
  input  logic                      memReady,
  output logic [WORD_W-OPC_W-2:0]   pcOut,
  output logic [WORD_W-1:0]         accOut,
  output logic                      intEnOut,
  output logic [1:0]                phase
);

  localparam int ADDR_W = WORD_W - OPC_W - 1;

  ctlStrobe_t       strobe;
  logic [OPC_W-1:0] irOp;
  logic             mbrInd;

  iccControl u_ctl (
    .clk(clk), .rstN(rstN), .memReady(memReady), .mbrInd(mbrInd),
    .irOp(irOp), .intEn(intEnOut), .intReq(intReq),
    .strobe(strobe), .phase(phase)
  );

  iccDatapath #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W),
    .HANDLER_ADDR(HANDLER_ADDR), .SP_INIT(SP_INIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .intEnSet(intEnSet),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .irOp(irOp), .mbrInd(mbrInd), .intEn(intEnOut),
    .pcOut(pcOut), .accOut(accOut)
  );

  assign memRd = strobe.memRd;
  assign memWr = strobe.memWr;

endmodule

// File: rtl/iccChecker.sv
module iccChecker
  import iccPkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 11,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = 11'h100
) (
  input logic              clk,
  input logic              rstN,
  input logic              intReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRd,
  input logic              memWr,
  input logic [WORD_W-1:0] memWdata,
  input logic              memReady,
  input logic [ADDR_W-1:0] pcOut,
  input logic              intEnOut,
  input logic [1:0]        phase
);

  p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && !memReady) |=> (memRd && $stable(memAddr)));

  p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && !memReady) |=> (memWr && $stable(memAddr) && $stable(memWdata)));

  p_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  p_pc_inc_r2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_FETCH && memRd && memReady) |=>
      (pcOut == ADDR_W'($past(pcOut) + 1'b1)));

  p_handler_r8: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_INT && memWr && memReady) |=>
      (pcOut == HANDLER_ADDR && phase == PH_FETCH));

  p_ie_clr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_INT && memWr) |=> !intEnOut);

  p_no_int_r7: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_EXEC && !(intEnOut && intReq)) |=> (phase != PH_INT));

endmodule

bind instrCycleCtl iccChecker #(
  .WORD_W(WORD_W), .ADDR_W(ADDR_W), .HANDLER_ADDR(HANDLER_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .intReq(intReq), .memAddr(memAddr),
  .memRd(memRd), .memWr(memWr), .memWdata(memWdata), .memReady(memReady),
  .pcOut(pcOut), .intEnOut(intEnOut), .phase(phase)
);

// File: tb/instrCycleCtl_test.sv
`timescale 1ns/1ps
module instrCycleCtl_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        intReq = 1'b0;
  logic        intEnSet = 1'b0;
  logic [10:0] memAddr;
  logic        memRd, memWr;
  logic [15:0] memWdata, memRdata;
  logic        memReady;
  logic [10:0] pcOut;
  logic [15:0] accOut;
  logic        intEnOut;
  logic [1:0]  phase;

  logic [15:0] mem [0:2047];
  int          waitN = 0;
  int          cnt = 0;
  int          checks = 0;
  int          errors = 0;
  bit          sawInd = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  instrCycleCtl uut (
    .clk(clk), .rstN(rstN), .intReq(intReq), .intEnSet(intEnSet),
    .memAddr(memAddr), .memRd(memRd), .memWr(memWr), .memWdata(memWdata),
    .memRdata(memRdata), .memReady(memReady), .pcOut(pcOut),
    .accOut(accOut), .intEnOut(intEnOut), .phase(phase)
  );

  assign memRdata = mem[memAddr];
  assign memReady = (memRd || memWr) && (cnt >= waitN);

  always @(posedge clk) begin
    if (memWr && memReady) mem[memAddr] = memWdata;
    if ((memRd || memWr) && !memReady) cnt <= cnt + 1;
    else cnt <= 0;
  end

  always @(negedge clk) if (rstN && phase == 2'd1) sawInd = 1;

  function automatic logic [15:0] enc(int op, int ind, int a);
    logic [3:0] o = op[3:0];
    logic [10:0] ad = a[10:0];
    return {o, ind[0], ad};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 2048; i++) mem[i] = 16'hDEAD;
  endtask

  task automatic doReset();
    rstN = 1'b0; intReq = 1'b0; intEnSet = 1'b0; sawInd = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic pulseIe();
    intEnSet = 1'b1;
    @(negedge clk);
    intEnSet = 1'b0;
  endtask

  task automatic checkPc(logic [10:0] loopAt, string req);
    check(pcOut == loopAt || pcOut == loopAt + 11'd1, req, pcOut, loopAt);
  endtask

  // direct program: load, add, store, jump over a store, then doubling
  task automatic runDirect(logic [15:0] a, logic [15:0] b);
    logic [15:0] s = a + b;
    clearMem();
    mem[11'h40] = a; mem[11'h41] = b;
    mem[0] = enc(1, 0, 'h40); mem[1] = enc(3, 0, 'h41);
    mem[2] = enc(2, 0, 'h42); mem[3] = enc(4, 0, 'h10);
    mem[4] = enc(2, 0, 'h44);
    mem[11'h10] = enc(1, 0, 'h42); mem[11'h11] = enc(3, 0, 'h42);
    mem[11'h12] = enc(2, 0, 'h45); mem[11'h13] = enc(4, 0, 'h13);
    doReset();
    repeat (600) @(negedge clk);
    check(mem[11'h42] == s, "R4 add+store", mem[11'h42], s);
    check(mem[11'h45] == 16'(s + s), "R4 reload/add", mem[11'h45], 16'(s + s));
    check(accOut == 16'(s + s), "R4 acc", accOut, 16'(s + s));
    check(mem[11'h44] == 16'hDEAD, "R4 jump skipped store", mem[11'h44], 16'hDEAD);
    check(!sawInd, "R3 no indirect phase", sawInd, 0);
    checkPc(11'h13, "R2 pc loop");
  endtask

  initial begin
    clearMem();
    // R1 reset state
    doReset();
    rstN = 1'b0;
    @(negedge clk);
    check(pcOut == 0 && phase == 0 && !intEnOut && !memRd && !memWr,
          "R1 in reset", {pcOut, phase, intEnOut, memRd, memWr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(pcOut == 0 && phase == 0 && !intEnOut, "R1 after release",
          {pcOut, phase, intEnOut}, 0);
    check(memRd && memAddr == 0, "R2 first fetch at pc 0", {memRd, memAddr}, {1'b1, 11'd0});

    // R4 R2 R6 sweep of wait states and operand values
    for (int w = 0; w < 4; w++) begin
      waitN = w;
      runDirect(16'd5, 16'd7);
      runDirect(16'hFFFF, 16'd2);
      runDirect(16'h1234, 16'h8000);
      runDirect(16'(w * 977), 16'(3 * w + 1));
    end

    // R3 indirect addressing
    for (int w = 0; w < 4; w++) begin
      logic [15:0] v = 16'(100 + 31 * w);
      waitN = w;
      clearMem();
      mem[11'h41] = 16'd9;
      mem[11'h50] = 16'h0060; mem[11'h51] = 16'h0070; mem[11'h52] = 16'h0020;
      mem[11'h60] = v;
      mem[0] = enc(1, 1, 'h50); mem[1] = enc(3, 0, 'h41);
      mem[2] = enc(2, 1, 'h51); mem[3] = enc(4, 1, 'h52);
      mem[11'h20] = enc(4, 0, 'h20);
      doReset();
      repeat (600) @(negedge clk);
      check(mem[11'h70] == v + 16'd9, "R3 indirect load/store", mem[11'h70], v + 16'd9);
      check(accOut == v + 16'd9, "R3 acc", accOut, v + 16'd9);
      check(mem[11'h51] == 16'h0070, "R3 pointer intact", mem[11'h51], 16'h0070);
      check(sawInd, "R3 indirect phase seen", sawInd, 1);
      checkPc(11'h20, "R3 indirect jump");
    end

    // R5 unused opcodes are no-ops
    waitN = 1;
    clearMem();
    mem[11'h40] = 16'd42; mem[11'h41] = 16'd17;
    mem[0] = enc(1, 0, 'h40); mem[1] = enc(0, 0, 'h41);
    mem[2] = enc(9, 0, 'h41); mem[3] = enc(15, 1, 'h41);
    mem[4] = enc(2, 0, 'h42); mem[5] = enc(4, 0, 5);
    doReset();
    repeat (400) @(negedge clk);
    check(accOut == 16'd42, "R5 acc unchanged", accOut, 42);
    check(mem[11'h42] == 16'd42, "R5 following store ran", mem[11'h42], 42);
    check(mem[11'h41] == 16'd17, "R5 memory untouched", mem[11'h41], 17);
    checkPc(11'd5, "R5 pc advanced");

    // R7 request ignored with enable clear
    waitN = 2;
    clearMem();
    mem[11'h40] = 16'd3; mem[11'h41] = 16'd4;
    mem[0] = enc(1, 0, 'h40); mem[1] = enc(3, 0, 'h41); mem[2] = enc(4, 0, 2);
    mem[11'h100] = enc(2, 0, 'h43); mem[11'h101] = enc(4, 0, 'h101);
    doReset();
    intReq = 1'b1;
    repeat (300) @(negedge clk);
    check(mem[11'h7FF] == 16'hDEAD, "R7 no save without enable", mem[11'h7FF], 16'hDEAD);
    check(mem[11'h43] == 16'hDEAD, "R7 handler not entered", mem[11'h43], 16'hDEAD);
    check(accOut == 16'd7, "R7 program ran", accOut, 7);
    checkPc(11'd2, "R7 pc in main loop");

    // R8 R9 interrupt entry after first instruction, then a second one
    doReset();
    intReq = 1'b1;
    pulseIe();
    check(intEnOut, "R9 enable set", intEnOut, 1);
    repeat (300) @(negedge clk);
    check(mem[11'h7FF] == 16'd1, "R8 saved pc", mem[11'h7FF], 1);
    check(mem[11'h43] == 16'd3, "R8 handler store", mem[11'h43], 3);
    check(accOut == 16'd3, "R8 add not run", accOut, 3);
    check(!intEnOut, "R8 enable cleared", intEnOut, 0);
    checkPc(11'h101, "R8 handler loop");
    pulseIe();
    repeat (200) @(negedge clk);
    check(mem[11'h7FE] == 16'h0101, "R8 second save at lower slot", mem[11'h7FE], 16'h0101);
    check(mem[11'h7FD] == 16'hDEAD, "R7 single entry per enable", mem[11'h7FD], 16'hDEAD);
    check(!intEnOut, "R8 enable cleared again", intEnOut, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule